// File: doc/BRIEF.md
# Exception Priority Resolver

This block decides which pending exception a processor core takes next and whether that exception may interrupt the context that is running now. Each exception owns one bit of a pending vector. The three lowest exception numbers are fixed-urgency system exceptions. Every higher number has an 8-bit priority that a simple write port loads. A grouping field selects how many low bits of each priority act as subpriority.

The block tracks entries and returns in a stack of active exceptions. From that stack it derives the current execution priority. When the best eligible pending exception beats that level in its group part, the block raises a one-cycle take strobe and pushes the exception onto the stack in the same clock edge. A return input pops the most recent entry.

All interfaces are plain control pins: there is no data stream and no back-pressure. The surrounding logic must clear a pending bit once its exception has been taken. An exception that is already active is never offered again, so a pending bit left set cannot cause a second take.

Top module: `exc_prio_resolver`

## Requirements
- R1: After reset no exception is active, `cur_prio_o` reads 256 (thread level) and `take_o` is low.
- R2: Exceptions 0, 1 and 2 have fixed priorities -3, -2 and -1. A write to any of these numbers changes nothing.
- R3: Exceptions 3 to N-1 have an 8-bit priority that resets to 0. A write through the port takes effect from the next cycle.
- R4: With grouping value g (0..7), the low g bits of a configurable priority are subpriority and the rest is group priority. `cur_prio_o` reports only the group part of the most urgent active exception, and changes to g act in the same cycle.
- R5: Among pending exceptions that are not active, the winner has the numerically lowest full priority, and a tie goes to the lower exception number. `win_vld_o` is high exactly when such a candidate exists.
- R6: `take_o` is high exactly when a winner exists, its group priority is strictly below `cur_prio_o`, and no return is requested.
- R7: A take pushes the winner. From the next cycle `cur_prio_o` is the lowest group priority over all active exceptions.
- R8: A return pops the most recent entry, and `cur_prio_o` is recomputed in the next cycle. A return with nothing active is ignored.
- R9: In a cycle with a return request, no exception is taken.
- R10: An active exception is excluded from arbitration even while its pending bit stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | N | Pending bit per exception number |
| ret_i | input | 1 | Exception return request |
| grp_i | input | 3 | Number of subpriority bits |
| prio_we_i | input | 1 | Priority write enable |
| prio_addr_i | input | log2(N) | Exception number to write |
| prio_data_i | input | 8 | Priority value to write |
| win_vld_o | output | 1 | An eligible pending exception exists |
| win_num_o | output | log2(N) | Winning exception number |
| take_o | output | 1 | Winner is taken this cycle |
| cur_prio_o | output | 10 | Current execution priority, two's complement |

## Verification
The embedded assertions watch the invariants on every cycle:
- a taken exception is pending and not already active;
- a return blocks any take;
- the active count matches the stack depth;
- locked entries never change;
- the level drops after each take.

Only the bench scenarios can show the actual orderings:
- tie-breaking by exception number;
- subpriority deciding arbitration but not preemption;
- a grouping change altering the current level immediately;
- returns restoring the previous level.

A reference model checks these against the outputs under random pending, write, return and grouping traffic.

// File: rtl/exc_res_pkg.sv
package exc_res_pkg;
  localparam int PW     = 10;
  localparam int NFIXED = 3;

  typedef logic signed [PW-1:0] sprio_t;

  localparam sprio_t THREAD_PRIO = 10'sd256;

  // Full (group + sub) priority of exception idx
  function automatic sprio_t full_prio(input int idx, input logic [7:0] p);
    if (idx < NFIXED) return sprio_t'(idx - 3);
    return sprio_t'({2'b00, p});
  endfunction

  // Group part: clear the low g subpriority bits, fixed levels untouched
  function automatic sprio_t group_of(input sprio_t f, input logic [2:0] g);
    sprio_t m;
    m = sprio_t'(10'h3FF << g);
    if (f < 0) return f;
    return f & m;
  endfunction
endpackage

// File: rtl/exc_prio_regs.sv
module exc_prio_regs
  import exc_res_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we_i,
  input  logic [IW-1:0]       addr_i,
  input  logic [7:0]          data_i,
  output logic [N-1:0][7:0]   prio_o
);

  for (genvar gi = 0; gi < N; gi++) begin : g_ent
    if (gi < NFIXED) begin : g_fixed
      assign prio_o[gi] = 8'h00;
    end else begin : g_cfg
      logic [7:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                r_q <= 8'h00;
        else if (we_i && addr_i == IW'(gi))        r_q <= data_i;
      end
      assign prio_o[gi] = r_q;
    end
  end

  AST_FIXED_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (we_i && addr_i < IW'(NFIXED)) |=> $stable(prio_o)); // R2

endmodule

// File: rtl/exc_prio_arbiter.sv
module exc_prio_arbiter
  import exc_res_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic [N-1:0]        elig_i,
  input  logic [N-1:0][7:0]   prio_i,
  output logic                win_vld_o,
  output logic [IW-1:0]       win_num_o,
  output sprio_t              win_full_o
);

  sprio_t key [N];

  for (genvar gi = 0; gi < N; gi++) begin : g_key
    assign key[gi] = full_prio(gi, prio_i[gi]);
  end

  // Linear scan: strict compare keeps the lower number on ties
  always_comb begin
    win_vld_o  = 1'b0;
    win_num_o  = '0;
    win_full_o = THREAD_PRIO;
    for (int i = 0; i < N; i++) begin
      if (elig_i[i] && (!win_vld_o || key[i] < win_full_o)) begin
        win_vld_o  = 1'b1;
        win_num_o  = IW'(i);
        win_full_o = key[i];
      end
    end
  end

endmodule

// File: rtl/exc_active_stack.sv
module exc_active_stack
  import exc_res_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                push_i,
  input  logic [IW-1:0]       push_num_i,
  input  logic                pop_i,
  input  logic [N-1:0][7:0]   prio_i,
  input  logic [2:0]          grp_i,
  output sprio_t              cur_prio_o,
  output logic [N-1:0]        act_o
);
  localparam int DW = IW + 1;

  logic [IW-1:0] stk_q [N];
  logic [DW-1:0] depth_q;
  logic [DW-1:0] top_idx;
  logic [N-1:0]  act_q;

  assign top_idx = depth_q - DW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      depth_q <= '0;
      act_q   <= '0;
    end else if (pop_i) begin
      if (depth_q != '0) begin
        act_q[stk_q[top_idx[IW-1:0]]] <= 1'b0;
        depth_q                      <= top_idx;
      end
    end else if (push_i) begin
      act_q[push_num_i] <= 1'b1;
      depth_q           <= depth_q + DW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (push_i && !pop_i) stk_q[depth_q[IW-1:0]] <= push_num_i;
  end

  // Current level: most urgent group priority over active entries
  always_comb begin
    sprio_t g;
    cur_prio_o = THREAD_PRIO;
    for (int i = 0; i < N; i++) begin
      g = group_of(full_prio(i, prio_i[i]), grp_i);
      if (act_q[i] && g < cur_prio_o) cur_prio_o = g;
    end
  end

  assign act_o = act_q;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (push_i && !pop_i) |-> (depth_q < DW'(N))); // R7
  AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (depth_q == '0) |-> (cur_prio_o == THREAD_PRIO)); // R1
  AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_i && depth_q == '0) |=> (depth_q == '0)); // R8
  AST_PUSH_FRESH: assert property (@(posedge clk) disable iff (!rst_n)
    push_i |-> !act_q[push_num_i]); // R10
  AST_DEPTH_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(act_q) == int'(depth_q))); // R8

endmodule

// File: rtl/exc_prio_resolver.sv
module exc_prio_resolver
  import exc_res_pkg::*;
#(
  parameter int N  = 16,
  parameter int IW = $clog2(N)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [N-1:0]    pend_i,
  input  logic            ret_i,
  input  logic [2:0]      grp_i,
  input  logic            prio_we_i,
  input  logic [IW-1:0]   prio_addr_i,
  input  logic [7:0]      prio_data_i,
  output logic            win_vld_o,
  output logic [IW-1:0]   win_num_o,
  output logic            take_o,
  output logic [PW-1:0]   cur_prio_o
);

  logic [N-1:0][7:0] prio;
  logic [N-1:0]      act;
  logic [N-1:0]      elig;
  sprio_t            win_full;
  sprio_t            cur;

  exc_prio_regs #(.N(N), .IW(IW)) u_regs (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (prio_we_i),
    .addr_i (prio_addr_i),
    .data_i (prio_data_i),
    .prio_o (prio)
  );

  assign elig = pend_i & ~act;

  exc_prio_arbiter #(.N(N), .IW(IW)) u_arb (
    .elig_i     (elig),
    .prio_i     (prio),
    .win_vld_o  (win_vld_o),
    .win_num_o  (win_num_o),
    .win_full_o (win_full)
  );

  // Preemption compares group parts only, and waits while a return is in flight
  assign take_o = win_vld_o && (group_of(win_full, grp_i) < cur) && !ret_i;

  exc_active_stack #(.N(N), .IW(IW)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .push_i     (take_o),
    .push_num_i (win_num_o),
    .pop_i      (ret_i),
    .prio_i     (prio),
    .grp_i      (grp_i),
    .cur_prio_o (cur),
    .act_o      (act)
  );

  assign cur_prio_o = cur;

  AST_TAKE_PEND: assert property (@(posedge clk) disable iff (!rst_n)
    take_o |-> pend_i[win_num_o]); // R5
  AST_WIN_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    win_vld_o |-> !act[win_num_o]); // R10
  AST_IDLE_NO_WIN: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_i == '0) |-> !win_vld_o); // R5
  AST_RET_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    ret_i |-> !take_o); // R9
  AST_TAKE_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
    (take_o && !prio_we_i) |=> (!$stable(grp_i) || cur < $past(cur))); // R7

endmodule

// File: tb/sim_exc_prio_resolver.sv
module sim_exc_prio_resolver;
  localparam int N  = 16;
  localparam int IW = $clog2(N);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] pend = '0;
  logic ret = 1'b0;
  logic [2:0] grp = 3'd0;
  logic we = 1'b0;
  logic [IW-1:0] addr = '0;
  logic [7:0] data = '0;
  logic win_vld, take;
  logic [IW-1:0] win_num;
  logic [9:0] cur_prio;

  always #2 clk = ~clk;

  exc_prio_resolver #(.N(N)) u0 (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .ret_i(ret), .grp_i(grp),
    .prio_we_i(we), .prio_addr_i(addr), .prio_data_i(data),
    .win_vld_o(win_vld), .win_num_o(win_num), .take_o(take), .cur_prio_o(cur_prio)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // Reference model state
  int m_prio [N];
  bit m_act  [N];
  int m_stk  [N];
  int m_depth = 0;
  // snapshots taken at check time
  int a_win, a_cur; bit a_vld, a_take;
  int e_win, e_cur; bit e_vld, e_take;

  function automatic int mfull(int i);
    return (i < 3) ? i - 3 : m_prio[i];
  endfunction

  function automatic int mgrp(int i);
    if (i < 3) return i - 3;
    return (m_prio[i] >> grp) << grp;
  endfunction

  task automatic chk(bit ok, string tag, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare();
    e_vld = 0; e_win = 0; e_cur = 256;
    for (int i = 0; i < N; i++)
      if (m_act[i] && mgrp(i) < e_cur) e_cur = mgrp(i);
    for (int i = 0; i < N; i++)
      if (pend[i] && !m_act[i] && (!e_vld || mfull(i) < mfull(e_win))) begin
        e_vld = 1; e_win = i;
      end
    e_take = e_vld && (mgrp(e_win) < e_cur) && !ret;
    a_vld = win_vld; a_win = int'(win_num); a_take = take;
    a_cur = int'($signed(cur_prio));
    chk(a_vld == e_vld, "R5 win_vld", a_vld, e_vld);
    if (e_vld) chk(a_win == e_win, "R5 win_num", a_win, e_win);
    chk(a_take == e_take, "R6 take", a_take, e_take);
    chk(a_cur == e_cur, "R7 cur_prio", a_cur, e_cur);
  endtask

  task automatic model_update();
    if (we && int'(addr) >= 3) m_prio[int'(addr)] = int'(data);
    if (ret) begin
      if (m_depth > 0) begin m_depth--; m_act[m_stk[m_depth]] = 0; end
    end else if (e_take) begin
      m_stk[m_depth] = e_win; m_act[e_win] = 1; m_depth++;
    end
  endtask

  task automatic step(logic [N-1:0] p, bit r, bit w, int a, int d, int g);
    @(negedge clk);
    pend = p; ret = r; we = w; addr = IW'(a); data = 8'(d); grp = 3'(g);
    #1; compare();
    @(posedge clk); model_update();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < N; i++) begin m_prio[i] = 0; m_act[i] = 0; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    step('0, 0, 0, 0, 0, 0);
    chk(a_cur == 256, "R1 reset level", a_cur, 256);
    chk(a_take == 0, "R1 reset take", a_take, 0);
    // reset value of a configurable priority is 0
    step(N'(1) << 3, 0, 0, 0, 0, 0);
    chk(a_take == 1, "R3 take at reset prio", a_take, 1);
    step('0, 0, 0, 0, 0, 0);
    chk(a_cur == 0, "R3 reset prio value", a_cur, 0);
    step('0, 1, 0, 0, 0, 0);
    step('0, 0, 1, 1, 8'hFF, 0);              // write to fixed NMI, ignored
    step('0, 0, 1, 5, 8'h40, 0);
    step('0, 0, 1, 7, 8'h40, 0);
    step('0, 0, 1, 9, 8'h80, 0);
    step((N'(1) << 5) | (N'(1) << 7), 0, 0, 0, 0, 0);
    chk(a_win == 5, "R5 tie lower number", a_win, 5);
    chk(a_take == 1, "R6 take from thread", a_take, 1);
    step((N'(1) << 5) | (N'(1) << 7), 0, 0, 0, 0, 0);
    chk(a_cur == 'h40, "R7 level after take", a_cur, 'h40);
    chk(a_take == 0, "R6 equal group no preempt", a_take, 0);
    chk(a_win == 7, "R10 active excluded", a_win, 7);
    step((N'(1) << 1) | (N'(1) << 7), 0, 0, 0, 0, 0);
    chk(a_take == 1 && a_win == 1, "R2 NMI preempts", a_win, 1);
    step(N'(1) << 7, 0, 0, 0, 0, 0);
    chk(a_cur == -2, "R2 NMI fixed level", a_cur, -2);
    step('0, 1, 0, 0, 0, 0);
    step('0, 0, 0, 0, 0, 0);
    chk(a_cur == 'h40, "R8 level restored", a_cur, 'h40);
    step('0, 0, 1, 10, 8'h20, 0);
    step(N'(1) << 10, 1, 0, 0, 0, 0);
    chk(a_take == 0, "R9 return blocks take", a_take, 0);
    chk(a_win == 10, "R9 winner still shown", a_win, 10);
    step(N'(1) << 10, 0, 0, 0, 0, 0);
    chk(a_cur == 256, "R8 pop to thread", a_cur, 256);
    chk(a_take == 1, "R6 take after return", a_take, 1);
    step('0, 0, 1, 11, 8'h10, 0);
    step(N'(1) << 11, 0, 0, 0, 0, 6);
    chk(a_cur == 0, "R4 group level", a_cur, 0);
    chk(a_take == 0, "R4 subpriority no preempt", a_take, 0);
    step(N'(1) << 11, 0, 0, 0, 0, 0);
    chk(a_take == 1, "R4 full group preempts", a_take, 1);
    step('0, 1, 0, 0, 0, 0);
    step('0, 1, 0, 0, 0, 0);
    step('0, 1, 0, 0, 0, 0);
    step('0, 0, 0, 0, 0, 0);
    chk(a_cur == 256, "R8 empty return ignored", a_cur, 256);

    for (int c = 0; c < 4000; c++) begin
      logic [N-1:0] p;
      int g;
      p = N'($urandom & $urandom & $urandom);
      g = (($urandom % 32) == 0) ? int'($urandom % 8) : int'(grp);
      step(p, ($urandom % 4) == 0, ($urandom % 4) == 0,
           int'($urandom % N), int'($urandom % 256), g);
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule